// File: doc/BRIEF.md
# Peripheral DMA Request Router

This block sits between a large set of peripheral DMA request lines and a smaller set of DMA channels. Software gives each request line a routing entry that names one target channel and a valid flag. While a request line's entry is valid, that line drives the request output of the channel it names. Several valid lines may name the same channel, and their requests merge into that channel's single request output.

The routing table is reached through a simple register port with separate read and write strobes. It is split across two address windows: the lower window holds the first 64 request lines and the upper window holds the rest. A read-only summary register at a fixed offset gathers one pending-interrupt bit per channel. Reads return data one cycle after the strobe. Any offset the block does not decode reads as zero and ignores writes.

Top module: `dreq_chan_mapper`

## Requirements
- R1: A routing entry holds a valid flag at data bit 7 and a channel number at bits 4:0. All other bits are ignored on write and read as zero. After reset every entry reads as zero (invalid, channel 0) and every channel request output is low.
- R2: Request line n with n below 64 has its entry at byte offset 0x0100 + 4*n.
- R3: Request line n with n of 64 or more has its entry at byte offset 0x1100 + 4*(n - 64).
- R4: Channel c's request output is high in cycle t+1 exactly when, in cycle t, some request line is high whose entry is valid and names channel c. A table write in cycle t takes effect for the routing of cycle t+1.
- R5: A high request line whose entry has bit 7 clear raises no channel request.
- R6: A read at offset 0x00F0 returns the per-channel interrupt inputs, with bit i equal to channel i's interrupt input in the read cycle and the upper bits zero. Writes to this offset change nothing.
- R7: Offsets that are misaligned, lie outside both windows, or decode to a request number at or above the number of request lines read as zero, and writes to them change no entry.
- R8: When several valid entries name the same channel, that channel's request output is the OR of their request lines.
- R9: A valid entry whose channel number is at or above the number of channels routes its request to no output.
- R10: Read data appears in the cycle after the read strobe and is zero in any cycle that follows a cycle with no read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write strobe for the register port |
| rd_en | input | 1 | Read strobe for the register port |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, one cycle after rd_en |
| req_i | input | NUM_REQ | Peripheral request lines |
| ch_irq_i | input | NUM_CH | Per-channel pending-interrupt inputs |
| ch_req_o | output | NUM_CH | Per-channel request outputs |

## Verification
The bench targets the seam between the two windows: entries 63 and 64 sit at 0x01FC and 0x1100, and a decoder that mixed up the window base or the index offset would read back or route through the wrong entry. It writes misaligned offsets, the first index beyond the request count, and the summary offset, then reads neighbouring entries; a loose decoder would alias those writes onto real entries. Entries that are invalid or that name channels beyond the channel count are driven with requests one at a time, so a router that ignored the valid flag or truncated the channel number would raise a stray output. Pseudo-random multi-line patterns with shared channels check the OR merge, which a priority pick or last-wins router would break.

// File: rtl/dmap_pkg.sv
package dmap_pkg;

  localparam int CH_W      = 5;
  localparam int VLD_POS   = 7;
  localparam int WIN_SPAN  = 64;
  localparam int LO_PAGE   = 'h01;
  localparam int HI_PAGE   = 'h11;
  localparam int SUM_OFS   = 'h00F0;

  typedef struct packed {
    logic            vld;
    logic [CH_W-1:0] ch;
  } map_entry_t;

endpackage

// File: rtl/dmap_decode.sv
module dmap_decode
  import dmap_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int NUM_REQ = 128,
  localparam int IDX_W  = $clog2(NUM_REQ)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              ent_hit_o,
  output logic [IDX_W-1:0]  ent_idx_o,
  output logic              sum_hit_o
);

  localparam int PAGE_W = ADDR_W - 8;

  logic [PAGE_W-1:0] page;
  logic              lo_win;
  logic              hi_win;
  logic              aligned;
  logic [6:0]        wide_idx;
  logic              in_range;

  always_comb begin
    page      = addr[ADDR_W-1:8];
    lo_win    = (page == PAGE_W'(LO_PAGE));
    hi_win    = (page == PAGE_W'(HI_PAGE));
    aligned   = (addr[1:0] == 2'b00);
    wide_idx  = {hi_win, addr[7:2]};
    in_range  = (int'(wide_idx) < NUM_REQ);
    ent_hit_o = (lo_win || hi_win) && aligned && in_range;
    ent_idx_o = wide_idx[IDX_W-1:0];
    sum_hit_o = (addr == ADDR_W'(SUM_OFS));
  end

endmodule

// File: rtl/dmap_table.sv
module dmap_table
  import dmap_pkg::*;
#(
  parameter int NUM_REQ = 128,
  localparam int IDX_W  = $clog2(NUM_REQ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  map_entry_t       wentry_i,
  output map_entry_t       tbl_o [NUM_REQ]
);

  for (genvar e = 0; e < NUM_REQ; e++) begin : g_ent
    map_entry_t ent_q;
    map_entry_t ent_nxt;
    logic       ent_we;

    always_comb begin
      ent_we  = we_i && (widx_i == IDX_W'(e));
      ent_nxt = ent_we ? wentry_i : ent_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= '0;
      end else begin
        ent_q <= ent_nxt;
      end
    end

    assign tbl_o[e] = ent_q;
  end

endmodule

// File: rtl/dmap_route.sv
module dmap_route
  import dmap_pkg::*;
#(
  parameter int NUM_REQ = 128,
  parameter int NUM_CH  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  map_entry_t         tbl_i [NUM_REQ],
  input  logic [NUM_REQ-1:0] req_i,
  output logic [NUM_CH-1:0]  ch_req_o
);

  logic [NUM_CH-1:0] req_nxt;
  logic [NUM_CH-1:0] req_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic any_hit;

    always_comb begin
      any_hit = 1'b0;
      for (int r = 0; r < NUM_REQ; r++) begin
        if (req_i[r] && tbl_i[r].vld && (tbl_i[r].ch == CH_W'(c))) begin
          any_hit = 1'b1;
        end
      end
    end

    assign req_nxt[c] = any_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
    end else begin
      req_q <= req_nxt;
    end
  end

  assign ch_req_o = req_q;

endmodule

// File: rtl/dreq_chan_mapper.sv
module dreq_chan_mapper
  import dmap_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int NUM_REQ = 128,
  parameter int NUM_CH  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic [NUM_REQ-1:0] req_i,
  input  logic [NUM_CH-1:0]  ch_irq_i,
  output logic [NUM_CH-1:0]  ch_req_o
);

  localparam int IDX_W = $clog2(NUM_REQ);

  logic              ent_hit;
  logic [IDX_W-1:0]  ent_idx;
  logic              sum_hit;
  map_entry_t        wentry;
  map_entry_t        tbl [NUM_REQ];
  map_entry_t        rd_ent;
  logic [DATA_W-1:0] rd_nxt;
  logic [DATA_W-1:0] rd_q;
  logic              wdata_unused;

  dmap_decode #(
    .ADDR_W  (ADDR_W),
    .NUM_REQ (NUM_REQ)
  ) u_decode (
    .addr      (addr),
    .ent_hit_o (ent_hit),
    .ent_idx_o (ent_idx),
    .sum_hit_o (sum_hit)
  );

  assign wentry.vld   = wdata[VLD_POS];
  assign wentry.ch    = wdata[CH_W-1:0];
  assign wdata_unused = ^{wdata[DATA_W-1:VLD_POS+1], wdata[VLD_POS-1:CH_W]};

  dmap_table #(
    .NUM_REQ (NUM_REQ)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_i     (wr_en && ent_hit),
    .widx_i   (ent_idx),
    .wentry_i (wentry),
    .tbl_o    (tbl)
  );

  dmap_route #(
    .NUM_REQ (NUM_REQ),
    .NUM_CH  (NUM_CH)
  ) u_route (
    .clk      (clk),
    .rst_n    (rst_n),
    .tbl_i    (tbl),
    .req_i    (req_i),
    .ch_req_o (ch_req_o)
  );

  always_comb begin
    rd_ent = tbl[ent_idx];
    rd_nxt = '0;
    if (rd_en) begin
      if (sum_hit) begin
        rd_nxt = DATA_W'(ch_irq_i);
      end else if (ent_hit) begin
        rd_nxt[VLD_POS]  = rd_ent.vld;
        rd_nxt[CH_W-1:0] = rd_ent.ch;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else begin
      rd_q <= rd_nxt;
    end
  end

  assign rdata = rd_q;

endmodule

// File: rtl/dmap_checker.sv
module dmap_checker
  import dmap_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int NUM_REQ = 128,
  parameter int NUM_CH  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rd_en,
  input logic [ADDR_W-1:0]  addr,
  input logic [DATA_W-1:0]  rdata,
  input logic [NUM_REQ-1:0] req_i,
  input logic [NUM_CH-1:0]  ch_irq_i,
  input logic [NUM_CH-1:0]  ch_req_o
);

  p_quiet_lines_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i == '0) |=> (ch_req_o == '0));

  p_misaligned_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr[1:0] != 2'b00)) |=> (rdata == '0));

  p_summary_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr == ADDR_W'(SUM_OFS))) |=> (rdata == DATA_W'($past(ch_irq_i))));

  p_idle_rdata_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en) |=> (rdata == '0));

endmodule

bind dreq_chan_mapper dmap_checker #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .NUM_REQ (NUM_REQ),
  .NUM_CH  (NUM_CH)
) u_dmap_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_en    (rd_en),
  .addr     (addr),
  .rdata    (rdata),
  .req_i    (req_i),
  .ch_irq_i (ch_irq_i),
  .ch_req_o (ch_req_o)
);

// File: tb/test_dreq_chan_mapper.sv
`timescale 1ns/1ps
module test_dreq_chan_mapper;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int NR = 80;
  localparam int NC = 8;

  logic          clk;
  logic          rst_n;
  logic          wr_en;
  logic          rd_en;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic [NR-1:0] req_i;
  logic [NC-1:0] ch_irq_i;
  logic [NC-1:0] ch_req_o;

  int   checks;
  int   failures;
  bit   done;
  logic [7:0] exp_tbl [NR];

  dreq_chan_mapper #(
    .ADDR_W (AW), .DATA_W (DW), .NUM_REQ (NR), .NUM_CH (NC)
  ) i_dreq_chan_mapper (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .rd_en (rd_en),
    .addr (addr), .wdata (wdata), .rdata (rdata), .req_i (req_i),
    .ch_irq_i (ch_irq_i), .ch_req_o (ch_req_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] ofs_of(int n);
    if (n < 64) return AW'(32'h0100 + n * 4);
    return AW'(32'h1100 + (n - 64) * 4);
  endfunction

  function automatic logic [NC-1:0] route_of(logic [NR-1:0] v);
    logic [NC-1:0] o = '0;
    for (int r = 0; r < NR; r++) begin
      if (v[r] && exp_tbl[r][7] && (int'(exp_tbl[r][4:0]) < NC)) o[exp_tbl[r][2:0]] = 1'b1;
    end
    return o;
  endfunction

  task automatic do_wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic drive_req(logic [NR-1:0] v, string tag);
    @(negedge clk);
    req_i = v;
    @(negedge clk);
    check(tag, DW'(ch_req_o), DW'(route_of(v)));
  endtask

  task automatic set_ent(int n, logic vld, logic [4:0] ch);
    exp_tbl[n] = {vld, 2'b00, ch};
    do_wr(ofs_of(n), {24'h5A5A5A, vld, 2'b11, ch});
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    logic [NR-1:0] lfsr;
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    req_i = '0; ch_irq_i = '0;
    for (int n = 0; n < NR; n++) exp_tbl[n] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    check("R1 reset outputs", DW'(ch_req_o), '0);
    check("R10 idle rdata", rdata, '0);
    for (int n = 0; n < NR; n++) begin
      do_rd(ofs_of(n), d);
      check("R1 reset entry", d, '0);
    end

    // R2 / R3: program every entry through its window, read back
    for (int n = 0; n < NR; n++) set_ent(n, (n % 3) != 0, 5'((n * 5 + 1) % 32));
    for (int n = 0; n < NR; n++) begin
      do_rd(ofs_of(n), d);
      check(n < 64 ? "R2 lower window readback" : "R3 upper window readback", d, DW'(exp_tbl[n]));
    end

    // R7: unmapped offsets
    do_wr(16'h0102, 32'h0000_009F);
    do_wr(16'h1140, 32'h0000_009F);
    do_wr(16'h0200, 32'h0000_009F);
    do_wr(16'h2100, 32'h0000_009F);
    do_wr(16'h0000, 32'h0000_009F);
    do_wr(16'h00F0, 32'h0000_009F);
    do_rd(16'h0100, d); check("R7 misaligned write ignored", d, DW'(exp_tbl[0]));
    do_rd(16'h1100, d); check("R7 outside write ignored hi", d, DW'(exp_tbl[64]));
    do_rd(16'h113C, d); check("R7 beyond-range write ignored", d, DW'(exp_tbl[79]));
    do_rd(16'h0102, d); check("R7 misaligned read", d, '0);
    do_rd(16'h1140, d); check("R7 beyond range read", d, '0);
    do_rd(16'h0200, d); check("R7 outside window read", d, '0);
    do_rd(16'h2100, d); check("R7 wrong page read", d, '0);
    @(negedge clk);
    check("R10 rdata clears", rdata, '0);

    // R4 / R5 / R9: single-line sweep
    for (int r = 0; r < NR; r++) begin
      drive_req(NR'(1) << r, !exp_tbl[r][7] ? "R5 invalid entry" :
                (exp_tbl[r][4:0] >= NC) ? "R9 channel out of range" : "R4 single route");
    end
    drive_req('0, "R4 no request");

    // R8: shared channel merge, and write-then-route timing (R4)
    set_ent(10, 1'b1, 5'd2);
    set_ent(70, 1'b1, 5'd2);
    drive_req(NR'(1) << 10, "R8 first sharer");
    drive_req(NR'(1) << 70, "R8 second sharer");
    drive_req((NR'(1) << 10) | (NR'(1) << 70), "R8 both sharers");
    lfsr = NR'(80'h9E37_79B9_7F4A_7C15_1234);
    for (int k = 0; k < 60; k++) begin
      lfsr = {lfsr[NR-2:0], lfsr[NR-1] ^ lfsr[NR-3] ^ lfsr[NR-5] ^ lfsr[NR-8]};
      drive_req(lfsr, "R8 random merge");
    end
    set_ent(10, 1'b0, 5'd2);
    drive_req(NR'(1) << 10, "R5 entry invalidated");

    // R6: summary sweep
    for (int v = 0; v < (1 << NC); v++) begin
      @(negedge clk);
      ch_irq_i = NC'(v); rd_en = 1'b1; addr = 16'h00F0;
      @(negedge clk);
      rd_en = 1'b0; ch_irq_i = ~NC'(v);
      check("R6 summary", rdata, DW'(v));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule